// File: doc/BRIEF.md
# Emulated pull-down input sampler

This block gives pull-down behaviour to a bank of bidirectional pins that have no pull-down resistor of their own. It runs a fixed, repeating schedule. First it drives every pin of the bank to logic 0 so that any charge on the floating node drains away. Then it releases the pins to high impedance and waits a settle time. During that wait an active switch recharges its pin through the external series resistor, while an inactive pin stays near ground. At the end of the wait the block captures the pins into a held output register. The rest of the design reads that register exactly as it would read an input with a real pull-down.

The pins are arranged as an array of groups with `NUM_GROUPS` groups of `GROUP_WIDTH` bits. A single group gives a plain 1-D bus. The drive-low time and the settle time are counted in clock cycles. The defaults are one cycle of drive and three cycles of settle, which at 100 MHz is the roughly 30 ns needed for an active pin to reach a valid high. Each pin has its own output-enable bit and drive-value bit, so the pad buffer can be built outside the block.

Top module: `pd_sampler`

## Requirements
- R1: While `rstN` is low, `level` is all zeros and every `padOe` bit is 1. The first cycle after reset is a drive cycle.
- R2: `padOut` is all zeros at all times, so the only level the block ever drives onto a pin is logic 0.
- R3: `padOe` is all ones for `DRIVE_CYCLES` consecutive cycles and then all zeros for `SETTLE_CYCLES`+1 cycles. The last of those zero cycles is the sample cycle. This pattern repeats with a period of `DRIVE_CYCLES`+`SETTLE_CYCLES`+1 cycles, which is 5 cycles with the defaults.
- R4: `level` changes only at the clock edge that ends a sample cycle. In every other cycle it holds its value.
- R5: The value loaded into `level` is the pin value present during the final settle cycle, which is the `SETTLE_CYCLES`-th cycle after release. That value passes through one synchronizer register on its way. A pin that is high in that cycle reads as 1, and a pin that is low reads as 0.
- R6: A pin that rises only in the sample cycle or later reads as 0 for that period. Pin values seen during drive cycles or the sample cycle never reach `level`.
- R7: All pins share one phase, so the bits of `padOe` are always all equal.
- R8: Pin bit b of group g (`padIn[g][b]`) lands only in `level[g][b]`. Groups and bits are captured independently of one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| padIn | input | NUM_GROUPS x GROUP_WIDTH | Value seen on each pin |
| padOe | output | NUM_GROUPS x GROUP_WIDTH | Drive enable for each pin (1 = drive) |
| padOut | output | NUM_GROUPS x GROUP_WIDTH | Value driven when enabled (always 0) |
| level | output | NUM_GROUPS x GROUP_WIDTH | Held sample, read like a pulled-down input |

## Verification
A wrong phase counter shows at once on `padOe`: the run of drive cycles or release cycles has the wrong length within the first period after reset. A capture strobe in the wrong cycle shows within one period. Either a switch that rises late is read as 1, or one that rises in the last settle cycle is read as 0. A mis-wired synchronizer or group index shows in `level` at the first sample that uses distinct per-group patterns. A missing hold on the output register shows as `level` moving in a cycle between samples.

// File: rtl/pd_pkg.sv
package pd_pkg;

  // Phases of the discharge / release / sample schedule
  typedef enum logic [1:0] {
    PH_DRIVE  = 2'd0,
    PH_SETTLE = 2'd1,
    PH_SAMPLE = 2'd2
  } phase_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic driveLow;  // pins actively pulled to 0
    logic capture;   // load the output register this cycle
  } pd_strobe_t;

endpackage

// File: rtl/pd_ctrl.sv
module pd_ctrl
  import pd_pkg::*;
#(
  parameter int DRIVE_CYCLES  = 1,
  parameter int SETTLE_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  output pd_strobe_t strb
);

  localparam int MAX_PHASE = (DRIVE_CYCLES > SETTLE_CYCLES) ? DRIVE_CYCLES : SETTLE_CYCLES;
  localparam int CNT_W     = $clog2(MAX_PHASE + 1);
  localparam logic [CNT_W-1:0] DRIVE_LAST  = CNT_W'(DRIVE_CYCLES - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);

  phase_e phaseQ, phaseD;
  logic [CNT_W-1:0] cntQ, cntD;

  always_comb begin
    phaseD = phaseQ;
    cntD   = cntQ + CNT_W'(1);
    unique case (phaseQ)
      PH_DRIVE: begin
        if (cntQ == DRIVE_LAST) begin
          phaseD = PH_SETTLE;
          cntD   = '0;
        end
      end
      PH_SETTLE: begin
        if (cntQ == SETTLE_LAST) begin
          phaseD = PH_SAMPLE;
          cntD   = '0;
        end
      end
      PH_SAMPLE: begin
        phaseD = PH_DRIVE;
        cntD   = '0;
      end
      default: begin
        phaseD = PH_DRIVE;
        cntD   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_DRIVE;
      cntQ   <= '0;
    end else begin
      phaseQ <= phaseD;
      cntQ   <= cntD;
    end
  end

  assign strb.driveLow = (phaseQ == PH_DRIVE);
  assign strb.capture  = (phaseQ == PH_SAMPLE);

  // Independent run-length counters for the checks below
  localparam int RUN_W = $clog2(MAX_PHASE + 2) + 1;
  logic [RUN_W-1:0] driveRun, settleRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveRun  <= '0;
      settleRun <= '0;
    end else begin
      driveRun  <= strb.driveLow ? driveRun + RUN_W'(1) : '0;
      settleRun <= (!strb.driveLow && !strb.capture) ? settleRun + RUN_W'(1) : '0;
    end
  end

  // R3
  drive_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.driveLow) |-> (driveRun == RUN_W'(DRIVE_CYCLES)));

  // R3
  settle_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> (settleRun == RUN_W'(SETTLE_CYCLES)));

  // R3
  sample_then_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> strb.driveLow);

endmodule

// File: rtl/pd_datapath.sv
module pd_datapath
  import pd_pkg::*;
#(
  parameter int NUM_GROUPS  = 3,
  parameter int GROUP_WIDTH = 8
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  pd_strobe_t                             strb,
  input  logic [NUM_GROUPS-1:0][GROUP_WIDTH-1:0] padIn,
  output logic [NUM_GROUPS-1:0][GROUP_WIDTH-1:0] padOe,
  output logic [NUM_GROUPS-1:0][GROUP_WIDTH-1:0] padOut,
  output logic [NUM_GROUPS-1:0][GROUP_WIDTH-1:0] level
);

  logic [NUM_GROUPS-1:0][GROUP_WIDTH-1:0] syncQ;
  logic [NUM_GROUPS-1:0][GROUP_WIDTH-1:0] levelQ;

  // One synchronizer stage, then the held sample register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '0;
      levelQ <= '0;
    end else begin
      syncQ <= padIn;
      if (strb.capture) levelQ <= syncQ;
    end
  end

  // Pad controls, one slice per group, all sharing the bank phase
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    assign padOe[g]  = {GROUP_WIDTH{strb.driveLow}};
    assign padOut[g] = '0;
  end

  assign level = levelQ;

  // R4
  level_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(levelQ));

  // R5
  capture_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (levelQ == $past(padIn, 2)));

endmodule

// File: rtl/pd_sampler.sv
module pd_sampler
  import pd_pkg::*;
#(
  parameter int NUM_GROUPS    = 3,
  parameter int GROUP_WIDTH   = 8,
  parameter int DRIVE_CYCLES  = 1,
  parameter int SETTLE_CYCLES = 3
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [NUM_GROUPS-1:0][GROUP_WIDTH-1:0] padIn,
  output logic [NUM_GROUPS-1:0][GROUP_WIDTH-1:0] padOe,
  output logic [NUM_GROUPS-1:0][GROUP_WIDTH-1:0] padOut,
  output logic [NUM_GROUPS-1:0][GROUP_WIDTH-1:0] level
);

  pd_strobe_t strb;

  pd_ctrl #(
    .DRIVE_CYCLES (DRIVE_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .strb(strb)
  );

  pd_datapath #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_WIDTH(GROUP_WIDTH)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .padIn (padIn),
    .padOe (padOe),
    .padOut(padOut),
    .level (level)
  );

  // R7
  oe_uniform_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padOe == '0) || (padOe == '1));

endmodule

// File: tb/pd_sampler_test.sv
module pd_sampler_test;

  localparam int GROUPS = 3;
  localparam int WIDTH  = 8;
  localparam int DRV    = 1;
  localparam int SETL   = 3;
  localparam int NP     = GROUPS * WIDTH;
  localparam int PERIOD = DRV + SETL + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [GROUPS-1:0][WIDTH-1:0] padIn, padOe, padOut, level;
  logic [GROUPS-1:0][WIDTH-1:0] sw = '0;   // switch closed = 1
  int riseDelay = 1;                        // cycles after release before an active pin reads high
  int relAge = 0;
  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  // Pin model: driven low wins; a released active pin rises after riseDelay cycles
  always @(posedge clk) relAge <= padOe[0][0] ? 0 : relAge + 1;
  always_comb padIn = sw & ~padOe & {NP{(relAge >= riseDelay)}};

  pd_sampler #(
    .NUM_GROUPS(GROUPS), .GROUP_WIDTH(WIDTH),
    .DRIVE_CYCLES(DRV), .SETTLE_CYCLES(SETL)
  ) uut (
    .clk(clk), .rstN(rstN), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .level(level)
  );

  task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Advance from a negedge to the negedge inside the next sample cycle
  task automatic toSample();
    while (!padOe[0][0]) @(negedge clk);
    while (padOe[0][0]) @(negedge clk);
    repeat (SETL) @(negedge clk);
  endtask

  task automatic testReset();
    sw = '1;
    repeat (3) begin
      @(negedge clk);
      check("R1 level in reset", level, '0);
      check("R1 padOe in reset", padOe, '1);
      check("R2 padOut in reset", padOut, '0);
    end
  endtask

  task automatic testPhase();
    sw = '0;
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 3 * PERIOD; i++) begin
      check("R3 R7 padOe schedule", padOe, ((i % PERIOD) < DRV) ? '1 : '0);
      check("R2 padOut", padOut, '0);
      @(negedge clk);
    end
  endtask

  task automatic testCapture();
    logic [NP-1:0] pat;
    pat = {8'hA5, 8'h3C, 8'h81};
    riseDelay = 1;
    while (!padOe[0][0]) @(negedge clk);
    sw = pat;
    toSample();
    check("R4 level before capture edge", level, '0);
    @(negedge clk);
    check("R5 R8 captured pattern", level, pat);
  endtask

  task automatic testHold();
    logic [NP-1:0] oldV, newV;
    oldV = level;
    newV = {8'h0F, 8'hF0, 8'h5A};
    sw = newV;  // now in a drive cycle: captured at this period's sample
    for (int i = 0; i < PERIOD; i++) begin
      check("R4 level held between samples", level, oldV);
      @(negedge clk);
    end
    check("R5 new pattern after next sample", level, newV);
  endtask

  task automatic testSlowRise();
    sw = '1;
    riseDelay = SETL;  // rises in the sample cycle: too late
    toSample();
    @(negedge clk);
    check("R6 late rise reads zero", level, '0);
    riseDelay = SETL - 1;  // rises in the last settle cycle: in time
    toSample();
    @(negedge clk);
    check("R5 rise in last settle cycle", level, '1);
    riseDelay = 1;
  endtask

  task automatic testGroups();
    logic [GROUPS-1:0][WIDTH-1:0] p;
    p = '0;
    p[0][0] = 1'b1;
    p[2][7] = 1'b1;
    sw = p;
    toSample();
    @(negedge clk);
    check("R8 single bits per group", level, p);
    p = '1;
    p[1] = '0;
    sw = p;
    toSample();
    @(negedge clk);
    check("R8 middle group clear", level, p);
    check("R2 padOut after samples", padOut, '0);
    sw = '0;
    toSample();
    @(negedge clk);
    check("R5 all switches open", level, '0);
  endtask

  initial begin
    testReset();
    testPhase();
    testCapture();
    testHold();
    testSlowRise();
    testGroups();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule